// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

A memory-mapped watchdog with a 16-bit register port. A prescaler turns the clock into a coarse tick of `TICK_CYCLES` clock cycles, 10 ms in the target system. A 15-bit down-counter is reloaded from a programmable timeout. Every action that starts, stops, reloads or clears the watchdog is guarded by a 16-bit key written to one particular register. A value that does not match the key does nothing. Stopping the timer takes two keys written in order.

The tick on which the count reaches zero raises an early-warning interrupt event. The next tick drives a reset pulse of `RST_PULSE_CYCLES` cycles, reloads the counter from the last timeout and lets it keep running. A timed-out flag records that the watchdog caused a reset. A warm reset input clears the rest of the block but leaves this flag in place, so software can see after the restart why the system was reset. While the debug input is high the counter freezes, unless software has set an override.

Registers are selected by a word index (byte offset / 4). A write takes effect at the clock edge where `wr_en` is sampled high. Read data is registered and is valid in the cycle after `rd_en`.

Top module: `keyed_watchdog`

## Requirements
- R1: After `rst` the timer is stopped (index 3 reads 0xDABE), index 4 reads 0x0000, the mask (index 9) is 0, the timeout (index 1) is 6000 = 0x1770, the event is 0, and `irq` and `wdt_rst` are low.
- R2: The timeout register at index 1 keeps only bits 14:0. Writing 0xFFFF reads back as 0x7FFF.
- R3: Writing 0xFEED to index 0 reloads the count from the timeout and restarts the prescaler. Any other value written there leaves the count unchanged.
- R4: Writing 0x2BAD to index 2 and then 0xCAFE to index 3 stops the timer. A 0xCAFE with no pending 0x2BAD has no effect. Any other write to index 2 or 3 cancels a pending 0x2BAD. Index 3 reads 0xDABE while stopped and 0x0000 while running. A stopped counter holds its value.
- R5: Writing 0xACED to index 7 starts a stopped timer. Any other value written there is ignored.
- R6: Index 5 returns the count in bits 14:0. Bit 15 is 1 when the count changes on the same edge that captures the read, which marks the value as stale, and 0 otherwise.
- R7: The tick that takes the count from 1 to 0 sets the event (index 8 bit 0). Writing 1 to index 8 bit 0 clears it, and writing 0 leaves it set. Writing 1 to index 10 bit 0 sets it. `irq` is the registered AND of the event and mask bit 0 at index 9. From a reload with timeout T, `irq` rises T·TICK_CYCLES+1 cycles later.
- R8: A tick while the count is 0 and the timer is running drives `wdt_rst` high for exactly `RST_PULSE_CYCLES` cycles, starting (T+1)·TICK_CYCLES cycles after the reload. The count reloads from the timeout and keeps counting, so the pulses repeat with that period.
- R9: A watchdog reset sets index 4 to read 0xCFE8. Writing 0xE8B4 clears it to 0x0000, and other values are ignored. Only `rst` clears the flag. `warm_rst` does not.
- R10: Index 6 bit 1 reads the `dbg_mode` input, and bit 0 is a writable override. While `dbg_mode` is high and the override is 0 the counter is frozen. With the override set, it keeps counting.
- R11: `warm_rst` returns every register except the timed-out flag to its R1 value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous power-on reset, active high, clears everything |
| warm_rst | input | 1 | Synchronous system reset, active high, keeps the timed-out flag |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| word_sel | input | 4 | Register word index |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data, valid the cycle after `rd_en` |
| dbg_mode | input | 1 | Debugger attached; freezes the counter unless overridden |
| irq | output | 1 | Early-warning interrupt, registered |
| wdt_rst | output | 1 | Watchdog reset pulse, registered |

## Verification
Each guarded register is driven with its correct key, with a wrong value, and for the disable pair with a correct key out of order or after a cancelling write. This separates a block that checks the full 16-bit key from one that reacts to any write. The counter is read on consecutive cycles while running, and the stale flags are compared with the change in count between the first and last reads. The interrupt and reset edges are timed from a reload with a small timeout, which exposes a missing or extra tick stage. A debug freeze with and without the override, and a warm reset after a timeout, show what each reset keeps and what each mode stops.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  localparam int DW = 16;

  // word indices; the decode depends on these positions
  localparam logic [3:0] IDX_FEED   = 4'd0;
  localparam logic [3:0] IDX_TMO    = 4'd1;
  localparam logic [3:0] IDX_DIS1   = 4'd2;
  localparam logic [3:0] IDX_DIS2   = 4'd3;
  localparam logic [3:0] IDX_STAT   = 4'd4;
  localparam logic [3:0] IDX_CNT    = 4'd5;
  localparam logic [3:0] IDX_DBG    = 4'd6;
  localparam logic [3:0] IDX_RESUME = 4'd7;
  localparam logic [3:0] IDX_EVT    = 4'd8;
  localparam logic [3:0] IDX_MASK   = 4'd9;
  localparam logic [3:0] IDX_FORCE  = 4'd10;

  localparam logic [DW-1:0] KEY_FEED     = 16'hFEED;
  localparam logic [DW-1:0] KEY_STOP_A   = 16'h2BAD;
  localparam logic [DW-1:0] KEY_STOP_B   = 16'hCAFE;
  localparam logic [DW-1:0] KEY_START    = 16'hACED;
  localparam logic [DW-1:0] KEY_FLAG_CLR = 16'hE8B4;

  localparam logic [DW-1:0] CODE_STOPPED = 16'hDABE;
  localparam logic [DW-1:0] CODE_EXPIRED = 16'hCFE8;
endpackage

// File: rtl/kwd_tick.sv
module kwd_tick #(
  parameter int TICK_CYCLES = 500000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  output logic tick
);
  localparam int PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_CYCLES - 1);

  logic [PW-1:0] div_q;

  assign tick = run && (div_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      div_q <= '0;
    end else if (run) begin
      div_q <= (div_q == LAST) ? '0 : div_q + PW'(1);
    end
  end
endmodule

// File: rtl/kwd_pulse.sv
module kwd_pulse #(
  parameter int WIDTH = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic pulse
);
  localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;

  logic [CW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
      pulse  <= 1'b0;
    end else if (start) begin
      left_q <= CW'(WIDTH - 1);
      pulse  <= 1'b1;
    end else if (left_q != '0) begin
      left_q <= left_q - CW'(1);
    end else begin
      pulse  <= 1'b0;
    end
  end
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import kwd_pkg::*;
#(
  parameter int TICK_CYCLES      = 500000,
  parameter int RST_PULSE_CYCLES = 16,
  parameter int CNT_W            = 15,
  parameter int TIMEOUT_INIT     = 6000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          warm_rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [3:0]    word_sel,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          dbg_mode,
  output logic          irq,
  output logic          wdt_rst
);
  localparam logic [CNT_W-1:0] TMO_RST = CNT_W'(TIMEOUT_INIT);

  logic any_rst;
  logic [CNT_W-1:0] tmo_q, count_q;
  logic en_q, armed_q, ovr_q, mask_q, evt_q, stat_q;
  logic feed_hit, stop_a_hit, stop_b_hit, start_hit, flag_clr_hit;
  logic run, tick, fire, warn;
  logic [DW-1:0] rd_cnt;

  assign any_rst = rst | warm_rst;

  // key decode
  assign feed_hit     = wr_en && word_sel == IDX_FEED   && wdata == KEY_FEED;
  assign stop_a_hit   = wr_en && word_sel == IDX_DIS1   && wdata == KEY_STOP_A;
  assign stop_b_hit   = wr_en && word_sel == IDX_DIS2   && wdata == KEY_STOP_B && armed_q;
  assign start_hit    = wr_en && word_sel == IDX_RESUME && wdata == KEY_START;
  assign flag_clr_hit = wr_en && word_sel == IDX_STAT   && wdata == KEY_FLAG_CLR;

  assign run  = en_q && (!dbg_mode || ovr_q);
  assign fire = tick && (count_q == '0);
  assign warn = tick && (count_q == CNT_W'(1));

  kwd_tick #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk  (clk),
    .rst  (any_rst),
    .clr  (feed_hit | start_hit),
    .run  (run),
    .tick (tick)
  );

  kwd_pulse #(.WIDTH(RST_PULSE_CYCLES)) u_pulse (
    .clk   (clk),
    .rst   (any_rst),
    .start (fire),
    .pulse (wdt_rst)
  );

  always_ff @(posedge clk) begin
    if (any_rst) begin
      tmo_q   <= TMO_RST;
      count_q <= TMO_RST;
      en_q    <= 1'b0;
      armed_q <= 1'b0;
      ovr_q   <= 1'b0;
      mask_q  <= 1'b0;
      evt_q   <= 1'b0;
      irq     <= 1'b0;
    end else begin
      if (wr_en && word_sel == IDX_TMO) tmo_q <= wdata[CNT_W-1:0];
      if (wr_en && word_sel == IDX_DBG) ovr_q <= wdata[0];
      if (wr_en && word_sel == IDX_MASK) mask_q <= wdata[0];

      if (feed_hit || fire) count_q <= tmo_q;
      else if (tick)        count_q <= count_q - CNT_W'(1);

      if (stop_b_hit)     en_q <= 1'b0;
      else if (start_hit) en_q <= 1'b1;

      if (stop_a_hit) armed_q <= 1'b1;
      else if (wr_en && (word_sel == IDX_DIS1 || word_sel == IDX_DIS2)) armed_q <= 1'b0;

      if (warn || (wr_en && word_sel == IDX_FORCE && wdata[0])) evt_q <= 1'b1;
      else if (wr_en && word_sel == IDX_EVT && wdata[0])        evt_q <= 1'b0;

      irq <= evt_q & mask_q;
    end
  end

  // timed-out flag: cleared by power-on reset only
  always_ff @(posedge clk) begin
    if (rst)               stat_q <= 1'b0;
    else if (fire)         stat_q <= 1'b1;
    else if (flag_clr_hit) stat_q <= 1'b0;
  end

  always_comb begin
    rd_cnt = '0;
    rd_cnt[CNT_W-1:0] = count_q;
    rd_cnt[DW-1] = tick | feed_hit;
  end

  always_ff @(posedge clk) begin
    if (any_rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      case (word_sel)
        IDX_TMO:  rdata <= DW'(tmo_q);
        IDX_DIS2: rdata <= en_q ? '0 : CODE_STOPPED;
        IDX_STAT: rdata <= stat_q ? CODE_EXPIRED : '0;
        IDX_CNT:  rdata <= rd_cnt;
        IDX_DBG:  rdata <= {{(DW-2){1'b0}}, dbg_mode, ovr_q};
        IDX_EVT:  rdata <= {{(DW-1){1'b0}}, evt_q};
        IDX_MASK: rdata <= {{(DW-1){1'b0}}, mask_q};
        default:  rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/kwd_checker.sv
module kwd_checker #(
  parameter int RST_PULSE_CYCLES = 16,
  parameter int CNT_W            = 15
) (
  input logic             clk,
  input logic             rst,
  input logic             warm_rst,
  input logic             dbg_mode,
  input logic             wdt_rst,
  input logic             irq,
  input logic             en_q,
  input logic             ovr_q,
  input logic             evt_q,
  input logic             stat_q,
  input logic [CNT_W-1:0] count_q,
  input logic             tick,
  input logic             feed_hit
);
  localparam int HW = $clog2(RST_PULSE_CYCLES + 2) + 1;
  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst || warm_rst) hi_cnt <= '0;
    else if (wdt_rst)    hi_cnt <= hi_cnt + HW'(1);
    else                 hi_cnt <= '0;
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!wdt_rst && !irq && !en_q));

  assert_hold_when_stopped_R4: assert property (@(posedge clk) disable iff (rst || warm_rst)
    (!en_q && !feed_hit) |=> $stable(count_q));

  assert_irq_from_event_R7: assert property (@(posedge clk) disable iff (rst || warm_rst)
    $rose(irq) |-> $past(evt_q));

  assert_pulse_bounded_R8: assert property (@(posedge clk) disable iff (rst || warm_rst)
    wdt_rst |-> (hi_cnt < HW'(RST_PULSE_CYCLES)));

  assert_pulse_length_R8: assert property (@(posedge clk) disable iff (rst || warm_rst)
    ($fell(wdt_rst) && !$past(warm_rst)) |-> (hi_cnt == HW'(RST_PULSE_CYCLES)));

  assert_fire_needs_enable_R8: assert property (@(posedge clk) disable iff (rst || warm_rst)
    $rose(wdt_rst) |-> $past(en_q));

  assert_flag_on_fire_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(wdt_rst) |-> stat_q);

  assert_debug_freeze_R10: assert property (@(posedge clk) disable iff (rst)
    (dbg_mode && !ovr_q) |-> !tick);
endmodule

bind keyed_watchdog kwd_checker #(
  .RST_PULSE_CYCLES(RST_PULSE_CYCLES),
  .CNT_W(CNT_W)
) u_kwd_chk (
  .clk      (clk),
  .rst      (rst),
  .warm_rst (warm_rst),
  .dbg_mode (dbg_mode),
  .wdt_rst  (wdt_rst),
  .irq      (irq),
  .en_q     (en_q),
  .ovr_q    (ovr_q),
  .evt_q    (evt_q),
  .stat_q   (stat_q),
  .count_q  (count_q),
  .tick     (tick),
  .feed_hit (feed_hit)
);

// File: tb/tb_keyed_watchdog.sv
module tb_keyed_watchdog;
  import kwd_pkg::*;

  localparam int TICK  = 4;
  localparam int PULSE = 3;
  localparam int TSML  = 3;

  logic clk = 1'b0, rst = 1'b1, warm_rst = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, dbg_mode = 1'b0;
  logic [3:0] word_sel = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic irq, wdt_rst;

  int checks = 0, errors = 0, cyc = 0;

  keyed_watchdog #(.TICK_CYCLES(TICK), .RST_PULSE_CYCLES(PULSE)) dut (
    .clk(clk), .rst(rst), .warm_rst(warm_rst), .wr_en(wr_en), .rd_en(rd_en),
    .word_sel(word_sel), .wdata(wdata), .rdata(rdata), .dbg_mode(dbg_mode),
    .irq(irq), .wdt_rst(wdt_rst)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual cycle %0d expected below 20000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input int req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] idx, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; word_sel = idx; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] idx, output logic [15:0] d);
    @(negedge clk);
    rd_en = 1'b1; word_sel = idx;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  // vector: {req[3:0], is_read, idx[3:0], data_or_expected[15:0]}
  localparam int NV = 38;
  localparam logic [24:0] VEC [NV] = '{
    {4'd1, 1'b1, IDX_DIS2, 16'hDABE},   // R1 stopped after reset
    {4'd1, 1'b1, IDX_STAT, 16'h0000},   // R1 flag clear
    {4'd1, 1'b1, IDX_MASK, 16'h0000},   // R1 mask clear
    {4'd1, 1'b1, IDX_TMO,  16'h1770},   // R1 default timeout 6000
    {4'd1, 1'b1, IDX_EVT,  16'h0000},   // R1 no event
    {4'd6, 1'b1, IDX_CNT,  16'h1770},   // R6 count, stable flag 0
    {4'd2, 1'b0, IDX_TMO,  16'hFFFF},   // R2 oversize write
    {4'd2, 1'b1, IDX_TMO,  16'h7FFF},   // R2 truncated to 15 bits
    {4'd2, 1'b0, IDX_TMO,  16'h0100},
    {4'd3, 1'b0, IDX_FEED, 16'h1234},   // R3 wrong key
    {4'd3, 1'b1, IDX_CNT,  16'h1770},   // R3 count unchanged
    {4'd3, 1'b0, IDX_FEED, 16'hFEED},   // R3 right key
    {4'd3, 1'b1, IDX_CNT,  16'h0100},   // R3 reloaded
    {4'd5, 1'b0, IDX_RESUME, 16'h1111}, // R5 wrong key
    {4'd5, 1'b1, IDX_DIS2, 16'hDABE},   // R5 still stopped
    {4'd5, 1'b0, IDX_RESUME, 16'hACED}, // R5 start key
    {4'd5, 1'b1, IDX_DIS2, 16'h0000},   // R5 running
    {4'd4, 1'b0, IDX_DIS2, 16'hCAFE},   // R4 second key alone
    {4'd4, 1'b1, IDX_DIS2, 16'h0000},   // R4 still running
    {4'd4, 1'b0, IDX_DIS1, 16'h2BAD},
    {4'd4, 1'b0, IDX_DIS1, 16'h0000},   // R4 cancel
    {4'd4, 1'b0, IDX_DIS2, 16'hCAFE},
    {4'd4, 1'b1, IDX_DIS2, 16'h0000},   // R4 cancelled, still running
    {4'd4, 1'b0, IDX_DIS1, 16'h2BAD},
    {4'd4, 1'b0, IDX_DIS2, 16'hCAFE},
    {4'd4, 1'b1, IDX_DIS2, 16'hDABE},   // R4 stopped
    {4'd7, 1'b0, IDX_MASK, 16'h0001},
    {4'd7, 1'b1, IDX_MASK, 16'h0001},   // R7 mask
    {4'd7, 1'b0, IDX_FORCE, 16'h0001},
    {4'd7, 1'b1, IDX_EVT,  16'h0001},   // R7 forced event
    {4'd7, 1'b0, IDX_EVT,  16'h0000},
    {4'd7, 1'b1, IDX_EVT,  16'h0001},   // R7 writing 0 keeps it
    {4'd7, 1'b0, IDX_EVT,  16'h0001},
    {4'd7, 1'b1, IDX_EVT,  16'h0000},   // R7 acknowledged
    {4'd10, 1'b1, IDX_DBG, 16'h0000},   // R10 no debug, no override
    {4'd10, 1'b0, IDX_DBG, 16'h0001},
    {4'd10, 1'b1, IDX_DBG, 16'h0001},   // R10 override bit
    {4'd10, 1'b0, IDX_DBG, 16'h0000}
  };

  initial begin
    logic [15:0] v, a, b;
    logic [15:0] burst [8];
    int flags, t0, c1, w, guard;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(1, "irq after reset", {15'd0, irq}, 16'd0);      // R1
    chk(1, "wdt_rst after reset", {15'd0, wdt_rst}, 16'd0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][20]) begin
        rd(VEC[i][19:16], v);
        chk(int'(VEC[i][24:21]), "table read", v, VEC[i][15:0]);
      end else begin
        wr(VEC[i][19:16], VEC[i][15:0]);
      end
    end

    // R7 irq follows forced event through mask, one cycle later
    chk(7, "irq idle", {15'd0, irq}, 16'd0);
    wr(IDX_FORCE, 16'h0001);
    @(negedge clk);
    chk(7, "irq after force", {15'd0, irq}, 16'd1);
    wr(IDX_EVT, 16'h0001);
    @(negedge clk);
    chk(7, "irq after ack", {15'd0, irq}, 16'd0);

    // R10 debug freeze, then override
    wr(IDX_RESUME, KEY_START);
    dbg_mode = 1'b1;
    rd(IDX_DBG, v);
    chk(10, "debug indication", v, 16'h0002);
    rd(IDX_CNT, a);
    repeat (20) @(negedge clk);
    rd(IDX_CNT, b);
    chk(10, "frozen count", b, a);
    wr(IDX_DBG, 16'h0001);
    rd(IDX_CNT, a);
    repeat (20) @(negedge clk);
    rd(IDX_CNT, b);
    chk(10, "override counts", {15'd0, b[14:0] < a[14:0]}, 16'd1);
    dbg_mode = 1'b0;
    wr(IDX_DBG, 16'h0000);

    // R6 back-to-back count reads: stale flags match the decrements
    @(negedge clk);
    rd_en = 1'b1; word_sel = IDX_CNT;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      burst[k] = rdata;
    end
    rd_en = 1'b0;
    flags = 0;
    for (int k = 0; k < 8; k++) if (burst[k][15]) flags++;
    chk(6, "stale flags in 8 reads", 16'(flags), 16'd2);
    flags = 0;
    for (int k = 0; k < 7; k++) if (burst[k][15]) flags++;
    chk(6, "count vs flags", {1'b0, burst[7][14:0]}, {1'b0, burst[0][14:0] - 15'(flags)});

    // R7 / R8 timing from a reload with a small timeout
    wr(IDX_TMO, 16'(TSML));
    wr(IDX_FEED, KEY_FEED);
    t0 = cyc;
    guard = 0;
    while (!irq && guard < 500) begin @(negedge clk); guard++; end
    chk(7, "irq delay", 16'(cyc - t0), 16'(TSML * TICK + 1));
    while (!wdt_rst && guard < 500) begin @(negedge clk); guard++; end
    c1 = cyc;
    chk(8, "reset delay", 16'(c1 - t0), 16'((TSML + 1) * TICK));
    w = 0;
    while (wdt_rst && guard < 500) begin w++; @(negedge clk); guard++; end
    chk(8, "pulse width", 16'(w), 16'(PULSE));
    while (!wdt_rst && guard < 500) begin @(negedge clk); guard++; end
    chk(8, "reset period", 16'(cyc - c1), 16'((TSML + 1) * TICK));

    // R9 flag set, wrong clear ignored
    rd(IDX_STAT, v);
    chk(9, "flag after timeout", v, CODE_EXPIRED);
    wr(IDX_STAT, 16'h1234);
    rd(IDX_STAT, v);
    chk(9, "wrong clear key", v, CODE_EXPIRED);
    wr(IDX_DIS1, KEY_STOP_A);
    wr(IDX_DIS2, KEY_STOP_B);

    // R11 warm reset keeps only the flag
    wr(IDX_DBG, 16'h0001);
    @(negedge clk);
    warm_rst = 1'b1;
    @(negedge clk);
    warm_rst = 1'b0;
    @(negedge clk);
    chk(11, "irq after warm reset", {15'd0, irq}, 16'd0);
    rd(IDX_STAT, v);
    chk(9, "flag survives warm reset", v, CODE_EXPIRED);
    rd(IDX_TMO, v);
    chk(11, "timeout after warm reset", v, 16'h1770);
    rd(IDX_MASK, v);
    chk(11, "mask after warm reset", v, 16'h0000);
    rd(IDX_DBG, v);
    chk(11, "override after warm reset", v, 16'h0000);
    rd(IDX_DIS2, v);
    chk(11, "stopped after warm reset", v, CODE_STOPPED);
    wr(IDX_STAT, KEY_FLAG_CLR);
    rd(IDX_STAT, v);
    chk(9, "flag cleared", v, 16'h0000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule